// File: doc/BRIEF.md
# SPI NAND Block Erase Sequencer

This block takes an erase request, given as a starting byte address and a byte length, and erases the covered 128 KiB blocks of a serial NAND device one after another. It does not drive the serial pins. It hands single command bytes to a byte-level SPI master and takes status bytes back from it. Each byte carries two flags: one marks the end of a chip-select frame, and one says that the master must return a response byte once the frame is done.

For every block the sequencer sends a write enable. It then looks the block up in a bad-block bitmap supplied from outside. If the block is good, it sends the block-erase command with the block's page-row address. It then reads the device status register repeatedly, up to a fixed number of reads, until the operation-in-progress bit clears. A block marked bad, an erase that fails, or a device that stays busy stops the run. The sequencer then sends a write disable, reports the failing block's byte address, and raises a one-cycle done pulse with an error code.

A request that is not block-aligned, or that reaches past the end of the device, is refused at once and causes no bus traffic. A request that is accepted produces a one-cycle pulse that tells the read path its cached page row is no longer valid.

Top module: `nand_erase_seq`

## Requirements
- R1: A request is refused when the address or the length has any of bits [16:0] set, or when address plus length is greater than NUM_BLOCKS*131072. The refusal is a done pulse with error code 1 in the cycle after the request, with fail_addr 0, no command bytes and no row_inval pulse.
- R2: A well-formed request of length 0 ends with a done pulse and error code 0 in the cycle after the request, with no command bytes.
- R3: For block b = address>>17, with row = b<<6, the command bytes go out in this order. First comes the frame 0x06. Then comes the frame 0xD8, 0x00, row[15:8], row[7:0]. Then come status-read frames 0x0F, 0xC0, and cmd_rd is set on the 0xC0 byte. cmd_last is set on the final byte of every frame.
- R4: The blocks from address>>17 up to (address+len)>>17 - 1 are erased in ascending order. When the last block's status shows bit 0 clear and bit 2 clear, the run ends with error code 0 and fail_addr 0, and no 0x04 frame is sent.
- R5: If bad_map[b] is 1, the 0x06 frame is followed by the frame 0x04 and no erase frame. The run ends with error code 2 and fail_addr = b<<17.
- R6: A status read is repeated while status bit 0 is 1, up to MAX_POLLS reads per block. If read number MAX_POLLS still has bit 0 set, a 0x04 frame follows and the run ends with error code 4 and fail_addr = b<<17.
- R7: If a status with bit 0 clear has bit 2 set, a 0x04 frame follows and the run ends with error code 3 and fail_addr = b<<17.
- R8: done is high for exactly one cycle per request. busy is high from the cycle after the request is accepted through the done cycle, and low afterwards. A req_valid seen while busy is high is ignored.
- R9: row_inval is high for exactly one cycle, in the cycle after a request that passes the R1 checks is accepted.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_byte, cmd_last and cmd_rd keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request strobe, taken while idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | 0 ok, 1 refused, 2 bad block, 3 erase fail, 4 busy timeout |
| fail_addr | output | ADDR_W | Byte address of the failing block |
| row_inval | output | 1 | Pulse: cached page row is stale |
| cmd_valid | output | 1 | Command byte offered |
| cmd_byte | output | 8 | Command byte |
| cmd_last | output | 1 | Final byte of a chip-select frame |
| cmd_rd | output | 1 | Frame expects one response byte |
| cmd_ready | input | 1 | SPI master takes the byte |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Status byte, bit 0 busy, bit 2 erase failure |
| bad_map | input | NUM_BLOCKS | Bad-block bitmap, bit b for block b |

## Verification
The assertions rely on three assumptions about the inputs. bad_map does not change during a request. rsp_valid pulses only while the sequencer waits after a status-read frame. The master does not take back cmd_ready for a byte it has already accepted. The bench's SPI model keeps to these. It returns exactly one status byte, two cycles after each frame flagged cmd_rd. It sets the bitmap, busy counts and failure flags only between requests. It takes bytes with cmd_ready either held high or stalling on every third cycle. The one stray req_valid arrives mid-run with an illegal length, so that any response to it would be visible.

// File: rtl/nes_pkg.sv
package nes_pkg;
   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_ALIGN   = 3'd1,
      ERR_BADBLK  = 3'd2,
      ERR_ERASE   = 3'd3,
      ERR_TIMEOUT = 3'd4
   } err_e;

   typedef enum logic [1:0] {FR_WREN, FR_ERASE, FR_POLL, FR_WRDIS} frame_e;

   typedef enum logic [3:0] {
      S_IDLE, S_WREN, S_BBCHK, S_ERASE, S_POLL_TX, S_POLL_RX, S_WRDIS, S_FINISH
   } state_e;

   localparam logic [7:0] OP_WREN    = 8'h06;
   localparam logic [7:0] OP_WRDIS   = 8'h04;
   localparam logic [7:0] OP_ERASE   = 8'hD8;
   localparam logic [7:0] OP_GETFEAT = 8'h0F;
   localparam logic [7:0] REG_STATUS = 8'hC0;
   localparam int ST_BUSY_BIT  = 0;
   localparam int ST_EFAIL_BIT = 2;
endpackage

// File: rtl/nes_req_check.sv
module nes_req_check #(
   parameter int ADDR_W     = 32,
   parameter int BLK_SHIFT  = 17,
   parameter int NUM_BLOCKS = 1024
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] len,
   output logic              ok,
   output logic              empty
);
   localparam logic [ADDR_W:0] DEV_BYTES = (ADDR_W+1)'(NUM_BLOCKS) << BLK_SHIFT;

   logic [ADDR_W:0] end_addr;

   always_comb begin
      end_addr = {1'b0, addr} + {1'b0, len};
      ok = (addr[BLK_SHIFT-1:0] == '0) && (len[BLK_SHIFT-1:0] == '0) &&
           (end_addr <= DEV_BYTES);
      empty = (len == '0);
   end
endmodule

// File: rtl/nes_frame_gen.sv
module nes_frame_gen import nes_pkg::*; #(
   parameter int BLK_W    = 10,
   parameter int PG_SHIFT = 6
) (
   input  frame_e           kind,
   input  logic [1:0]       idx,
   input  logic [BLK_W-1:0] blk,
   output logic [7:0]       byte_o,
   output logic             last_o,
   output logic             rd_o
);
   logic [15:0] row;

   always_comb begin
      row    = 16'(blk) << PG_SHIFT;
      byte_o = OP_WREN;
      last_o = 1'b1;
      rd_o   = 1'b0;
      case (kind)
         FR_WREN:  byte_o = OP_WREN;
         FR_WRDIS: byte_o = OP_WRDIS;
         FR_ERASE: begin
            last_o = (idx == 2'd3);
            case (idx)
               2'd0:    byte_o = OP_ERASE;
               2'd1:    byte_o = 8'h00;
               2'd2:    byte_o = row[15:8];
               default: byte_o = row[7:0];
            endcase
         end
         default: begin
            last_o = (idx == 2'd1);
            rd_o   = (idx == 2'd1);
            byte_o = (idx == 2'd0) ? OP_GETFEAT : REG_STATUS;
         end
      endcase
   end
endmodule

// File: rtl/nes_poll_ctr.sv
module nes_poll_ctr #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last_try
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (inc)      cnt <= cnt + CW'(1);
   end

   assign last_try = (cnt == CW'(LIMIT - 1));

   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT)) else $error("poll count past limit"); // R6
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq import nes_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int NUM_BLOCKS = 1024,
   parameter int BLK_SHIFT  = 17,
   parameter int PG_SHIFT   = 6,
   parameter int MAX_POLLS  = 100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [ADDR_W-1:0]     req_len,
   output logic                  busy,
   output logic                  done,
   output logic [2:0]            err,
   output logic [ADDR_W-1:0]     fail_addr,
   output logic                  row_inval,
   output logic                  cmd_valid,
   output logic [7:0]            cmd_byte,
   output logic                  cmd_last,
   output logic                  cmd_rd,
   input  logic                  cmd_ready,
   input  logic                  rsp_valid,
   input  logic [7:0]            rsp_byte,
   input  logic [NUM_BLOCKS-1:0] bad_map
);
   localparam int BLK_W = $clog2(NUM_BLOCKS);
   localparam int RW    = BLK_W + 1;

   if (NUM_BLOCKS < 2) begin : g_chk_blocks
      $error("NUM_BLOCKS must be at least 2");
   end
   if (ADDR_W < BLK_SHIFT + RW) begin : g_chk_addr
      $error("ADDR_W too narrow for device size");
   end
   if (BLK_W + PG_SHIFT > 16) begin : g_chk_row
      $error("row address exceeds 16 bits");
   end
   if (MAX_POLLS < 1) begin : g_chk_polls
      $error("MAX_POLLS must be at least 1");
   end

   state_e           state;
   logic [1:0]       bidx;
   logic [BLK_W-1:0] blk;
   logic [RW-1:0]    remain;
   logic             chk_ok, chk_empty;
   frame_e           kind;
   logic             cmd_fire, last_try, poll_inc;
   logic             rsp_busy, rsp_efail;
   logic             rsp_unused;

   nes_req_check #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NUM_BLOCKS(NUM_BLOCKS)) u_check (
      .addr(req_addr), .len(req_len), .ok(chk_ok), .empty(chk_empty));

   nes_frame_gen #(.BLK_W(BLK_W), .PG_SHIFT(PG_SHIFT)) u_frame (
      .kind(kind), .idx(bidx), .blk(blk),
      .byte_o(cmd_byte), .last_o(cmd_last), .rd_o(cmd_rd));

   assign rsp_busy   = rsp_byte[ST_BUSY_BIT];
   assign rsp_efail  = rsp_byte[ST_EFAIL_BIT];
   assign rsp_unused = ^{rsp_byte[7:3], rsp_byte[1]};
   assign poll_inc   = (state == S_POLL_RX) && rsp_valid && rsp_busy && !last_try;

   nes_poll_ctr #(.LIMIT(MAX_POLLS)) u_poll (
      .clk(clk), .rst_n(rst_n), .clr(state == S_BBCHK), .inc(poll_inc),
      .last_try(last_try));

   always_comb begin
      case (state)
         S_ERASE:   kind = FR_ERASE;
         S_POLL_TX: kind = FR_POLL;
         S_WRDIS:   kind = FR_WRDIS;
         default:   kind = FR_WREN;
      endcase
      cmd_valid = (state == S_WREN) || (state == S_ERASE) ||
                  (state == S_POLL_TX) || (state == S_WRDIS);
   end

   assign cmd_fire = cmd_valid && cmd_ready;
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_FINISH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         bidx      <= '0;
         blk       <= '0;
         remain    <= '0;
         err       <= ERR_NONE;
         fail_addr <= '0;
         row_inval <= 1'b0;
      end else begin
         row_inval <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               err       <= ERR_NONE;
               fail_addr <= '0;
               bidx      <= '0;
               if (!chk_ok) begin
                  err   <= ERR_ALIGN;
                  state <= S_FINISH;
               end else begin
                  row_inval <= 1'b1;
                  blk       <= req_addr[BLK_SHIFT +: BLK_W];
                  remain    <= req_len[BLK_SHIFT +: RW];
                  state     <= chk_empty ? S_FINISH : S_WREN;
               end
            end
            S_WREN, S_ERASE, S_POLL_TX, S_WRDIS: if (cmd_fire) begin
               if (cmd_last) begin
                  bidx <= '0;
                  case (state)
                     S_WREN:    state <= S_BBCHK;
                     S_ERASE:   state <= S_POLL_TX;
                     S_POLL_TX: state <= S_POLL_RX;
                     default:   state <= S_FINISH;
                  endcase
               end else begin
                  bidx <= bidx + 2'd1;
               end
            end
            S_BBCHK: begin
               if (bad_map[blk]) begin
                  err       <= ERR_BADBLK;
                  fail_addr <= ADDR_W'(blk) << BLK_SHIFT;
                  state     <= S_WRDIS;
               end else begin
                  state <= S_ERASE;
               end
            end
            S_POLL_RX: if (rsp_valid) begin
               if (rsp_busy) begin
                  if (last_try) begin
                     err       <= ERR_TIMEOUT;
                     fail_addr <= ADDR_W'(blk) << BLK_SHIFT;
                     state     <= S_WRDIS;
                  end else begin
                     state <= S_POLL_TX;
                  end
               end else if (rsp_efail) begin
                  err       <= ERR_ERASE;
                  fail_addr <= ADDR_W'(blk) << BLK_SHIFT;
                  state     <= S_WRDIS;
               end else if (remain == RW'(1)) begin
                  state <= S_FINISH;
               end else begin
                  blk    <= blk + BLK_W'(1);
                  remain <= remain - RW'(1);
                  state  <= S_WREN;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R8
   AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy) else $error("done without busy"); // R8
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err == ERR_ALIGN) |-> $past(!busy && !cmd_valid)) else $error("refusal not immediate"); // R1
   AST_NO_ERASE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_fire && state == S_ERASE && bidx == 2'd0) |-> !bad_map[blk]) else $error("erase on bad block"); // R5
   AST_FAIL_CLEANUP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err >= ERR_BADBLK) |-> $past(cmd_fire && cmd_byte == OP_WRDIS)) else $error("failure without write disable"); // R7
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_last) && $stable(cmd_rd))) else $error("command byte changed while stalled"); // R10
   AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      row_inval |=> !row_inval) else $error("row_inval longer than one cycle"); // R9
endmodule

// File: tb/nand_erase_seq_test.sv
module nand_erase_seq_test;
   localparam int NB = 8;
   localparam int MP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0, req_len = '0;
   logic        busy, done, row_inval, cmd_valid, cmd_last, cmd_rd;
   logic [2:0]  err;
   logic [31:0] fail_addr;
   logic [7:0]  cmd_byte;
   logic        cmd_ready = 1'b0, rsp_valid = 1'b0;
   logic [7:0]  rsp_byte = '0;
   logic [NB-1:0] bad_map = '0;

   nand_erase_seq #(.ADDR_W(32), .NUM_BLOCKS(NB), .MAX_POLLS(MP)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .busy(busy), .done(done), .err(err),
      .fail_addr(fail_addr), .row_inval(row_inval), .cmd_valid(cmd_valid),
      .cmd_byte(cmd_byte), .cmd_last(cmd_last), .cmd_rd(cmd_rd),
      .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
      .bad_map(bad_map));

   always #4 clk = ~clk;

   int checks = 0, errors = 0;
   int busy_left [NB];
   bit efail [NB];
   logic [7:0] exp_b [256];
   logic [7:0] log_b [256];
   int exp_n = 0, log_n = 0;
   int inval_cnt = 0, done_cnt = 0;
   bit stall = 1'b0;
   int cyc = 0, pos = 0, rsp_delay = 0, cur_blk = 0;
   logic [7:0] row_hi = '0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // SPI master and device model, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      rsp_valid = 1'b0;
      if (rsp_delay > 0) begin
         rsp_delay--;
         if (rsp_delay == 0) begin
            rsp_valid = 1'b1;
            if (busy_left[cur_blk] > 0) begin
               busy_left[cur_blk]--;
               rsp_byte = 8'h01;
            end else begin
               rsp_byte = efail[cur_blk] ? 8'h04 : 8'h00;
            end
         end
      end
      cmd_ready = !stall || (cyc % 3 != 1);
      if (row_inval) inval_cnt++;
      if (done) done_cnt++;
      if (cmd_valid && cmd_ready) begin
         if (log_n < 256) log_b[log_n] = cmd_byte;
         log_n++;
         if (pos == 2) row_hi = cmd_byte;
         if (pos == 3 && log_b[log_n-4] == 8'hD8) cur_blk = int'({row_hi, cmd_byte} >> 6);
         if (cmd_rd) rsp_delay = 2;
         pos = cmd_last ? 0 : pos + 1;
      end
   end

   task automatic push(input logic [7:0] b);
      exp_b[exp_n] = b;
      exp_n++;
   endtask

   task automatic build_exp(input int s, input int n, output int e, output logic [31:0] fa);
      exp_n = 0; e = 0; fa = 0;
      for (int b = s; b < s + n; b++) begin
         logic [15:0] row;
         int reads;
         row = 16'(b << 6);
         push(8'h06);
         if (bad_map[b]) begin push(8'h04); e = 2; fa = b << 17; return; end
         push(8'hD8); push(8'h00); push(row[15:8]); push(row[7:0]);
         reads = (busy_left[b] >= MP) ? MP : busy_left[b] + 1;
         for (int r = 0; r < reads; r++) begin push(8'h0F); push(8'hC0); end
         if (busy_left[b] >= MP) begin push(8'h04); e = 4; fa = b << 17; return; end
         if (efail[b]) begin push(8'h04); e = 3; fa = b << 17; return; end
      end
   endtask

   task automatic clear_dev();
      bad_map = '0;
      for (int b = 0; b < NB; b++) begin busy_left[b] = 0; efail[b] = 0; end
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] l, input int ee,
                      input logic [31:0] efa, input int einv, input string tag, input bit poke);
      int mism;
      int w;
      log_n = 0; inval_cnt = 0; done_cnt = 0; pos = 0;
      @(negedge clk);
      req_addr = a; req_len = l; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, {tag, " R8 busy after accept"}, busy, 1);
      w = 0;
      while (!done && w < 5000) begin
         if (poke && w == 6) begin req_valid = 1'b1; req_addr = 0; req_len = 32'h123; end
         else req_valid = 1'b0;
         @(negedge clk);
         w++;
      end
      req_valid = 1'b0;
      chk(done == 1'b1, {tag, " R8 done seen"}, done, 1);
      chk(err == 3'(ee), {tag, " err code"}, err, ee);
      chk(fail_addr == efa, {tag, " fail_addr"}, fail_addr, efa);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, {tag, " R8 done single, busy low"}, {done, busy}, 0);
      chk(done_cnt == 1, {tag, " R8 done pulse count"}, done_cnt, 1);
      chk(inval_cnt == einv, {tag, " R9 row_inval count"}, inval_cnt, einv);
      mism = -1;
      for (int i = 0; i < exp_n && i < log_n; i++) if (mism < 0 && log_b[i] != exp_b[i]) mism = i;
      chk(log_n == exp_n, {tag, " byte count"}, log_n, exp_n);
      chk(mism < 0, {tag, " byte sequence"}, (mism < 0) ? 0 : log_b[mism], (mism < 0) ? 0 : exp_b[mism]);
   endtask

   task automatic good_run(input int s, input int n, input string tag, input bit poke);
      int e;
      logic [31:0] fa;
      build_exp(s, n, e, fa);
      run(32'(s) << 17, 32'(n) << 17, e, fa, 1, tag, poke);
   endtask

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_dev();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !cmd_valid && !row_inval, "reset state R8", {busy, done, cmd_valid, row_inval}, 0);

      // R2 R3 R4 R10: sweep every start block and block count
      for (int s = 0; s < NB; s++) begin
         for (int n = 0; n <= NB - s; n++) begin
            clear_dev();
            for (int b = 0; b < NB; b++) busy_left[b] = (b + s) % MP;
            stall = ((s + n) % 2) == 1;
            good_run(s, n, (n == 0) ? "R2 empty" : "R3 R4 R10 sweep", 1'b0);
         end
      end
      stall = 1'b0;

      // R1: refusals
      clear_dev();
      exp_n = 0;
      run(32'(6) << 17, 32'(3) << 17, 1, 0, 0, "R1 past end", 1'b0);
      run(32'h0, 32'(9) << 17, 1, 0, 0, "R1 too long", 1'b0);
      run((32'(1) << 17) | 32'h800, 32'(1) << 17, 1, 0, 0, "R1 addr offset", 1'b0);
      run(32'(2) << 17, (32'(1) << 17) + 32'h1, 1, 0, 0, "R1 len offset", 1'b0);
      run(32'h10000, 32'h0, 1, 0, 0, "R1 half block addr", 1'b0);

      // R5: bad block at each position of a full-device run
      for (int b = 0; b < NB; b++) begin
         clear_dev();
         bad_map[b] = 1'b1;
         stall = (b % 2) == 1;
         good_run(0, NB, "R5 bad block", 1'b0);
      end
      stall = 1'b0;

      // R6: busy exactly at the limit and one read short of it
      clear_dev();
      busy_left[3] = MP;
      good_run(2, 3, "R6 timeout", 1'b0);
      clear_dev();
      busy_left[3] = MP - 1;
      good_run(2, 3, "R6 last read clears", 1'b0);

      // R7: erase failure reported by status
      clear_dev();
      efail[5] = 1'b1;
      busy_left[5] = 2;
      good_run(4, 3, "R7 erase fail", 1'b0);
      clear_dev();
      efail[0] = 1'b1;
      good_run(0, 1, "R7 erase fail first", 1'b0);

      // R8: request during busy ignored
      clear_dev();
      busy_left[1] = 1;
      good_run(1, 2, "R8 ignore while busy", 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule